// File: doc/BRIEF.md
# Interrupt Controller Command and Status-Read Unit

This unit is the command and read-back path of an eight-input priority interrupt controller. It keeps three registers: the pending-request register (IRR), the in-service register (ISR) and the mask register. It takes byte writes on two ports. On the command port, a write is either a control word or a level word. A control word picks the register that command-port reads return, arms a one-shot poll, and can switch special mask mode on or off. A level word ends service for a level, either a named level or the most urgent one.

A poll read acts as an interrupt acknowledge. It returns an encoded byte that names the winning level, marks that level in service, and clears its pending bit. Writes to the data port load the mask. Reads from the data port return the mask. The `int_req` output shows whether any request can currently be granted. Reads cannot be stalled: every read strobe gives exactly one `rd_valid` pulse one cycle later, so there is no back-pressure path.

Top module: `pic_cmd_unit`

## Requirements
- R1: After an active-low reset, IRR, ISR and mask are zero, special mask mode is off, no poll is armed, the read selection is IRR, `int_req` is 0 and `rd_valid` is 0.
- R2: A command-port write with bits 4:3 = 01 and bit 7 = 0 is a control word. A write with bits 4:3 = 01 and bit 7 = 1 changes no selection, poll or mode state.
- R3: In a control word, bits 1:0 = 10 select IRR and 11 select ISR for command-port reads. The values 00 and 01 keep the current selection.
- R4: The selected register is returned on every command-port read until a new control word changes the selection.
- R5: A one-cycle `init_done` pulse sets the read selection to IRR. It takes precedence over a control word written in the same cycle.
- R6: A control word with bit 2 set arms a poll. The next command-port read returns 1000_0lll (lll = winning level) and sets that level's ISR bit and clears its IRR bit. If nothing can be granted, the read returns 00h. The poll is then disarmed.
- R7: Special mask mode takes control-word bit 6 only when bit 5 is 1. With bit 5 = 0 the mode is unchanged.
- R8: A command-port write with bits 4:3 = 00 is a level word. Bits 7:5 = 011 clear the ISR bit named by bits 2:0. Bits 7:5 = 001 clear the lowest-numbered ISR bit and ignore bits 2:0. Other codes change nothing.
- R9: An IRR bit is set by a rising edge on its request line and cleared only by a poll acknowledge of that level.
- R10: A data-port write loads the mask from bits 7:0, and a data-port read returns it. The mask blocks granting but never alters IRR.
- R11: Priority is fixed with level 0 highest. Outside special mask mode, a pending, unmasked level is blocked when that level or any lower-numbered level is in service.
- R12: In special mask mode, only the mask and the level's own ISR bit block a pending request.
- R13: `int_req` is 1 exactly when some level is pending, unmasked and not blocked.
- R14: Every read strobe produces `rd_valid` high with the data in the following cycle, and `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Pulse at the end of initialization; restores IRR read selection |
| reg_sel | input | 1 | Port select: 0 command port, 1 data (mask) port |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle pulse the cycle after `rd_en` |
| irq_req | input | 8 | Raw request lines, one per level |
| int_req | output | 1 | A grantable request exists |

## Verification
The hardest states to reach from the ports are ISR holding several bits at once, and ISR bits sitting above pending lower-priority requests. The only way to set ISR is a poll acknowledge. The stimulus therefore builds ISR out of chains of poll reads. In normal mode, every second poll in a chain must come back empty. In special mask mode, one chain collects all unmasked levels in ascending order. The bench then unwinds ISR with non-specific and named end-of-service words. It sweeps every request pattern under two derived masks.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    RSEL_IRR = 1'b0,
    RSEL_ISR = 1'b1
  } rsel_e;

  typedef struct packed {
    logic       rd_upd;
    rsel_e      rd_sel;
    logic       poll;
    logic       smm_upd;
    logic       smm_val;
    logic       eoi_spec;
    logic       eoi_any;
    logic [2:0] lvl;
  } cmd_t;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode import pic_cmd_pkg::*; (
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] byte_in,
  output cmd_t              cmd
);
  logic is_ctl;
  logic is_lvl;

  always_comb begin
    is_ctl       = wr_cmd && (byte_in[4:3] == 2'b01) && !byte_in[7];
    is_lvl       = wr_cmd && (byte_in[4:3] == 2'b00);
    cmd.rd_upd   = is_ctl && byte_in[1];
    cmd.rd_sel   = rsel_e'(byte_in[0]);
    cmd.poll     = is_ctl && byte_in[2];
    cmd.smm_upd  = is_ctl && byte_in[5];
    cmd.smm_val  = byte_in[6];
    cmd.eoi_spec = is_lvl && (byte_in[7:5] == 3'b011);
    cmd.eoi_any  = is_lvl && (byte_in[7:5] == 3'b001);
    cmd.lvl      = byte_in[2:0];
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NUM_LEVELS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] req_in,
  input  logic [NUM_LEVELS-1:0] ack_clr,
  output logic [NUM_LEVELS-1:0] irr
);
  logic [NUM_LEVELS-1:0] req_q;
  logic [NUM_LEVELS-1:0] rise;

  assign rise = req_in & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irr   <= '0;
    end else begin
      req_q <= req_in;
      irr   <= (irr & ~ack_clr) | rise;
    end
  end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int NUM_LEVELS = 8,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic [NUM_LEVELS-1:0] irr,
  input  logic [NUM_LEVELS-1:0] isr,
  input  logic [NUM_LEVELS-1:0] mask,
  input  logic                  smm,
  output logic [NUM_LEVELS-1:0] grant,
  output logic [LVL_W-1:0]      win,
  output logic                  any
);
  logic [NUM_LEVELS-1:0] svc_upto;
  logic [NUM_LEVELS-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_first
        assign svc_upto[g] = isr[g];
      end else begin : g_rest
        assign svc_upto[g] = svc_upto[g-1] | isr[g];
      end
      assign elig[g] = irr[g] & ~mask[g] & ~(smm ? isr[g] : svc_upto[g]);
    end
  endgenerate

  assign grant = elig & (~elig + {{(NUM_LEVELS-1){1'b0}}, 1'b1});
  assign any   = |elig;

  always_comb begin
    win = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (elig[i]) win = LVL_W'(i);
    end
  end
endmodule

// File: rtl/pic_cmd_unit.sv
module pic_cmd_unit import pic_cmd_pkg::*; #(
  parameter int NUM_LEVELS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_done,
  input  logic                  reg_sel,
  input  logic                  wr_en,
  input  logic [7:0]            wr_data,
  input  logic                  rd_en,
  output logic [7:0]            rd_data,
  output logic                  rd_valid,
  input  logic [NUM_LEVELS-1:0] irq_req,
  output logic                  int_req
);
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  cmd_t                  cmd;
  logic [NUM_LEVELS-1:0] irr;
  logic [NUM_LEVELS-1:0] isr;
  logic [NUM_LEVELS-1:0] mask;
  logic                  smm;
  logic                  poll_armed;
  rsel_e                 rsel;
  logic [NUM_LEVELS-1:0] grant_vec;
  logic [LVL_W-1:0]      win;
  logic                  win_any;
  logic                  poll_rd;
  logic [NUM_LEVELS-1:0] ack_vec;
  logic [NUM_LEVELS-1:0] eoi_clr;
  logic [NUM_LEVELS-1:0] isr_low;
  logic [BYTE_W-1:0]     poll_byte;
  logic [BYTE_W-1:0]     rd_next;

  pic_cmd_decode u_dec (
    .wr_cmd  (wr_en && !reg_sel),
    .byte_in (wr_data),
    .cmd     (cmd)
  );

  pic_req_latch #(.NUM_LEVELS(NUM_LEVELS)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (irq_req),
    .ack_clr (ack_vec),
    .irr     (irr)
  );

  pic_prio_resolve #(.NUM_LEVELS(NUM_LEVELS)) u_prio (
    .irr   (irr),
    .isr   (isr),
    .mask  (mask),
    .smm   (smm),
    .grant (grant_vec),
    .win   (win),
    .any   (win_any)
  );

  assign int_req = win_any;
  assign poll_rd = rd_en && !reg_sel && poll_armed;
  assign ack_vec = poll_rd ? grant_vec : '0;
  assign isr_low = isr & (~isr + {{(NUM_LEVELS-1){1'b0}}, 1'b1});

  always_comb begin
    eoi_clr = '0;
    if (cmd.eoi_any) eoi_clr = isr_low;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (cmd.eoi_spec && (cmd.lvl == 3'(i))) eoi_clr[i] = 1'b1;
    end
  end

  always_comb begin
    poll_byte = '0;
    if (win_any) poll_byte = {1'b1, 4'b0000, 3'(win)};
    if (reg_sel)          rd_next = BYTE_W'(mask);
    else if (poll_armed)  rd_next = poll_byte;
    else if (rsel == RSEL_ISR) rd_next = BYTE_W'(isr);
    else                  rd_next = BYTE_W'(irr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr        <= '0;
      mask       <= '0;
      smm        <= 1'b0;
      poll_armed <= 1'b0;
      rsel       <= RSEL_IRR;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      isr      <= (isr & ~eoi_clr) | ack_vec;
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
      if (wr_en && reg_sel) mask <= wr_data[NUM_LEVELS-1:0];
      if (cmd.smm_upd) smm <= cmd.smm_val;
      if (cmd.poll)       poll_armed <= 1'b1;
      else if (poll_rd)   poll_armed <= 1'b0;
      if (init_done)      rsel <= RSEL_IRR;
      else if (cmd.rd_upd) rsel <= cmd.rd_sel;
    end
  end
endmodule

// File: rtl/pic_cmd_unit_chk.sv
module pic_cmd_unit_chk #(
  parameter int NUM_LEVELS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  init_done,
  input logic                  reg_sel,
  input logic                  wr_en,
  input logic [7:0]            wr_data,
  input logic                  rd_en,
  input logic [7:0]            rd_data,
  input logic                  rd_valid,
  input logic [NUM_LEVELS-1:0] irr,
  input logic [NUM_LEVELS-1:0] isr,
  input logic [NUM_LEVELS-1:0] mask,
  input logic                  smm,
  input logic                  rsel,
  input logic                  poll_armed,
  input logic [NUM_LEVELS-1:0] grant
);
  logic       ctl_wr;
  logic       poll_q;
  logic [7:0] poll_exp_q;
  logic [7:0] poll_exp;

  assign ctl_wr = wr_en && !reg_sel && (wr_data[4:3] == 2'b01) && !wr_data[7];

  always_comb begin
    poll_exp = 8'h00;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (grant[i]) poll_exp = 8'h80 | 8'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_q     <= 1'b0;
      poll_exp_q <= 8'h00;
    end else begin
      poll_q     <= rd_en && !reg_sel && poll_armed;
      poll_exp_q <= poll_exp;
    end
  end

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R14
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R14
  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !reg_sel && poll_armed && !(ctl_wr && wr_data[2])) |=> !poll_armed); // R6
  AST_POLL_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && poll_q) |-> (rd_data == poll_exp_q)); // R6
  AST_ISR_SET_BY_POLL: assert property (@(posedge clk) disable iff (!rst_n) (|(isr & ~$past(isr))) |-> $past(rd_en && !reg_sel && poll_armed)); // R6
  AST_SMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(ctl_wr && wr_data[5]) |=> $stable(smm)); // R7
  AST_SMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && wr_data[5]) |=> (smm == $past(wr_data[6]))); // R7
  AST_RSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ctl_wr && wr_data[1] && !init_done) |=> (rsel == $past(wr_data[0]))); // R3
  AST_RSEL_INIT: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> !rsel); // R5
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R11
  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n) ((grant & ~irr) == '0)); // R9
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n) ((grant & mask) == '0)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && reg_sel) |=> $stable(mask)); // R10
endmodule

bind pic_cmd_unit pic_cmd_unit_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_done  (init_done),
  .reg_sel    (reg_sel),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .irr        (irr),
  .isr        (isr),
  .mask       (mask),
  .smm        (smm),
  .rsel       (rsel),
  .poll_armed (poll_armed),
  .grant      (grant_vec)
);

// File: tb/test_pic_cmd_unit.sv
module test_pic_cmd_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_done = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] irq_req = 8'h00;
  logic       int_req;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_irr, m_isr, m_mask, m_line;
  logic       m_smm;

  always #4 clk = ~clk;

  pic_cmd_unit i_pic_cmd_unit (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_req(irq_req), .int_req(int_req)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_elig(input logic [7:0] irr, input logic [7:0] isr,
                                        input logic [7:0] msk, input logic smm);
    logic [7:0] e;
    logic [7:0] upto;
    e = 8'h00;
    for (int i = 0; i < 8; i++) begin
      upto = 8'((16'd2 << i) - 16'd1);
      if (irr[i] && !msk[i] && (smm ? !isr[i] : ((isr & upto) == 8'h00))) e[i] = 1'b1;
    end
    return e;
  endfunction

  function automatic int f_low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check8("R14 rd_valid", {7'b0, rd_valid}, 8'h01);
    d = rd_data;
  endtask

  task automatic do_reset();
    irq_req = 8'h00; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_irr = 0; m_isr = 0; m_mask = 0; m_line = 0; m_smm = 0;
  endtask

  task automatic set_irq(input logic [7:0] p);
    @(negedge clk); irq_req = p;
    m_irr = m_irr | (p & ~m_line); m_line = p;
    @(negedge clk);
  endtask

  task automatic set_mask(input logic [7:0] m);
    wr(1'b1, m); m_mask = m;
  endtask

  task automatic do_poll(input string req);
    logic [7:0] got, e, expv;
    int w;
    wr(1'b0, 8'h0C);
    rd(1'b0, got);
    e = f_elig(m_irr, m_isr, m_mask, m_smm);
    expv = 8'h00;
    if (e != 8'h00) begin
      w = f_low(e); expv = 8'h80 | 8'(w); m_isr[w] = 1'b1; m_irr[w] = 1'b0;
    end
    check8(req, got, expv);
  endtask

  task automatic rd_irr(input string req);
    logic [7:0] got;
    wr(1'b0, 8'h0A); rd(1'b0, got); check8(req, got, m_irr);
  endtask

  task automatic rd_isr(input string req);
    logic [7:0] got;
    wr(1'b0, 8'h0B); rd(1'b0, got); check8(req, got, m_isr);
  endtask

  task automatic eoi_any();
    wr(1'b0, 8'h20);
    if (m_isr != 8'h00) m_isr[f_low(m_isr)] = 1'b0;
  endtask

  task automatic eoi_lvl(input int l);
    wr(1'b0, 8'h60 | 8'(l)); m_isr[l] = 1'b0;
  endtask

  task automatic chk_int(input string req);
    check8(req, {7'b0, int_req}, {7'b0, (f_elig(m_irr, m_isr, m_mask, m_smm) != 8'h00)});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    do_reset();
    // R1 reset state
    check8("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    check8("R1 int_req", {7'b0, int_req}, 8'h00);
    rd(1'b0, got); check8("R1 default IRR read", got, 8'h00);
    rd(1'b1, got); check8("R1 mask", got, 8'h00);
    rd_isr("R1 isr");

    // normal-mode sweep over every request pattern (R9 R10 R11 R13)
    for (int p = 0; p < 256; p++) begin
      do_reset();
      set_mask(8'(p * 29) & 8'hAA);
      set_irq(8'(p));
      chk_int("R13 int_req");
      rd_irr("R9 irr latch under mask R10");
      for (int k = 0; k < 10 && f_elig(m_irr, m_isr, m_mask, m_smm) != 8'h00; k++) begin
        do_poll("R11 poll winner");
        do_poll("R11 blocked by service");
        chk_int("R13 after ack");
        eoi_any();
      end
      rd_irr("R10 masked remain");
    end

    // special mask mode sweep (R12 R8)
    for (int p = 0; p < 256; p++) begin
      do_reset();
      set_mask(8'(p * 53) & 8'h55);
      wr(1'b0, 8'h68); m_smm = 1'b1;
      set_irq(8'(p));
      chk_int("R13 smm int_req");
      for (int k = 0; k < 10 && f_elig(m_irr, m_isr, m_mask, m_smm) != 8'h00; k++)
        do_poll("R12 smm poll order");
      rd_isr("R12 smm isr collect");
      for (int l = 7; l >= 0; l--) eoi_lvl(l);
      rd_isr("R8 specific eoi");
    end

    // selection, persistence, one-shot poll
    do_reset();
    set_irq(8'h05);
    do_poll("R6 poll acknowledge");
    rd(1'b0, got); check8("R6 one-shot back to IRR", got, 8'h04);
    wr(1'b0, 8'h0B);
    for (int k = 0; k < 3; k++) begin
      rd(1'b0, got); check8("R4 repeated ISR read", got, 8'h01);
    end
    wr(1'b0, 8'h08); rd(1'b0, got); check8("R3 code 00 keeps", got, 8'h01);
    wr(1'b0, 8'h09); rd(1'b0, got); check8("R3 code 01 keeps", got, 8'h01);
    wr(1'b0, 8'h8A); rd(1'b0, got); check8("R2 bit7 word ignored", got, 8'h01);
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    rd(1'b0, got); check8("R5 init restores IRR", got, 8'h04);
    wr(1'b0, 8'h8C); rd(1'b0, got); check8("R2 bit7 poll ignored", got, 8'h04);
    @(negedge clk); check8("R14 rd_valid drops", {7'b0, rd_valid}, 8'h00);
    rd_isr("R2 isr unchanged");

    // mode enable (R7), blocking (R11 R12)
    chk_int("R11 blocked by level0");
    wr(1'b0, 8'h48);
    check8("R7 no enable no change", {7'b0, int_req}, 8'h00);
    wr(1'b0, 8'h68); m_smm = 1'b1;
    check8("R7 smm on", {7'b0, int_req}, 8'h01);
    do_poll("R12 smm second grant");
    wr(1'b0, 8'h28); m_smm = 1'b0;
    // level words (R8)
    wr(1'b0, 8'hC3);
    rd_isr("R8 non-eoi code");
    wr(1'b0, 8'h27); m_isr[0] = 1'b0;
    rd_isr("R8 nonspecific ignores level bits");
    eoi_lvl(1); rd_isr("R8 specific unset level");
    eoi_lvl(2); rd_isr("R8 specific clear");
    do_poll("R6 empty poll");

    // mask port (R10), re-arm edge (R9)
    set_mask(8'hA5);
    rd(1'b1, got); check8("R10 mask readback", got, 8'hA5);
    set_irq(8'h00);
    set_irq(8'h04);
    rd_irr("R9 second rising edge");

    summary();
    $finish;
  end
endmodule